// File: doc/BRIEF.md
# Pipeline Issue Hazard Checker

This block sits at the decode boundary of an in-order five-stage pipeline and decides, every cycle, whether the instruction now decoded may enter execution. It keeps a small pool of in-flight instructions. For each one it records the registers read, the register written, whether it is a load or a branch, and the stage it has reached. The new instruction is compared with every live entry. A conflict is sorted into read-after-write, write-after-write or write-after-read. The block then either lets the instruction issue or holds it with a stall.

A read-after-write conflict against a producer whose result is already on a bypass path is reported as forwardable, so no stall is needed. A load still in execute cannot be bypassed in time, and its consumer waits one cycle. A branch holds back the next instruction until it resolves. The pool entries advance one stage per clock in lockstep. Every entry, ALU or load, writes back in stage 5, so the single write port reported by the block is never contended.

Top module: `hz_issue_check`

## Requirements
- R1: After reset the pool is empty, and while `in_valid` is 0 the outputs `stall`, `issue_ok`, `hz_kind` and `fwd_ok` are all 0.
- R2: `hz_kind[0]` (read-after-write) is 1 when an enabled source of the new instruction equals the destination of a live entry. A source whose enable is 0 never matches.
- R3: `fwd_ok` is 1 exactly when a read-after-write conflict exists and every conflicting producer is either a non-load at stage 3 or later, or a load at stage 4 or later. A forwardable read-after-write conflict alone causes no stall.
- R4: A read-after-write conflict on a load in stage 3 stalls the consumer. Held one cycle, the same consumer then issues with forwarding.
- R5: `hz_kind[1]` (write-after-write) is 1 when the new destination equals a live entry's destination. It stalls while that entry remains in the pool, including its stage-5 cycle.
- R6: `hz_kind[2]` (write-after-read) is 1 when the new destination equals an enabled source of a live entry at stage 3 or earlier. It stalls only in that case.
- R7: Register 0 never forms a dependence, as a source or as a destination, and is never reported as written back.
- R8: After a branch issues, the next instruction is stalled for exactly 2 cycles.
- R9: A stalled instruction is not inserted into the pool. An issued instruction enters at stage 3, advances one stage per cycle and leaves after stage 5.
- R10: `wb_en`/`wb_reg` report the destination of the entry in stage 5, exactly 3 cycles after its issue cycle, for loads and ALU operations alike. At most one entry is in stage 5 in any cycle.
- R11: `issue_ok` equals `in_valid` and not `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_dst | input | 5 | Destination register (0 = no write) |
| in_src_a | input | 5 | First source register |
| in_src_a_en | input | 1 | First source is read |
| in_src_b | input | 5 | Second source register |
| in_src_b_en | input | 1 | Second source is read |
| in_load | input | 1 | Instruction is a load |
| in_branch | input | 1 | Instruction is a branch |
| stall | output | 1 | Hold the presented instruction |
| issue_ok | output | 1 | Instruction enters the pipeline at this edge |
| hz_kind | output | 3 | Bit 0 RAW, bit 1 WAW, bit 2 WAR |
| fwd_ok | output | 1 | All RAW conflicts are covered by bypass |
| wb_en | output | 1 | A register is written back this cycle |
| wb_reg | output | 5 | Register written back |

## Verification
The hardest situations to reach are the ones that depend on an older entry sitting in one particular stage. Examples are a load in execute as opposed to memory, a reader still at stage 3, and a writer in its last cycle in the pool. The stimulus reaches them by holding the same instruction on the inputs across several cycles while earlier issued entries walk forward. The expected stall pattern changes cycle by cycle as each entry crosses a stage boundary, and the write-back report three cycles after each issue confirms the stage each entry was in.

// File: rtl/hz_pkg.sv
package hz_pkg;
   localparam int HK_W   = 3;
   localparam int HK_RAW = 0;
   localparam int HK_WAW = 1;
   localparam int HK_WAR = 2;
   typedef logic [HK_W-1:0] hz_kind_t;
endpackage

// File: rtl/hz_window.sv
module hz_window #(
   parameter int REG_W  = 5,
   parameter int DEPTH  = 4,
   parameter int STG_W  = 3,
   parameter int STG_EX = 3,
   parameter int STG_WB = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ins_en,
   input  logic [REG_W-1:0]                ins_dst,
   input  logic [REG_W-1:0]                ins_a,
   input  logic                            ins_a_en,
   input  logic [REG_W-1:0]                ins_b,
   input  logic                            ins_b_en,
   input  logic                            ins_ld,
   input  logic                            ins_br,
   output logic [DEPTH-1:0]                e_v,
   output logic [DEPTH-1:0][REG_W-1:0]     e_dst,
   output logic [DEPTH-1:0][REG_W-1:0]     e_a,
   output logic [DEPTH-1:0]                e_a_en,
   output logic [DEPTH-1:0][REG_W-1:0]     e_b,
   output logic [DEPTH-1:0]                e_b_en,
   output logic [DEPTH-1:0]                e_ld,
   output logic [DEPTH-1:0]                e_br,
   output logic [DEPTH-1:0][STG_W-1:0]     e_stg,
   output logic                            full
);
   localparam logic [STG_W-1:0] S_EX = STG_W'(STG_EX);
   localparam logic [STG_W-1:0] S_WB = STG_W'(STG_WB);

   logic [DEPTH-1:0] sel;

   // lowest free slot as a one-hot vector
   assign sel  = ~e_v & (e_v + DEPTH'(1));
   assign full = &e_v;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic             v_q, a_en_q, b_en_q, ld_q, br_q;
      logic [REG_W-1:0] dst_q, a_q, b_q;
      logic [STG_W-1:0] stg_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q    <= 1'b0;
            stg_q  <= '0;
            dst_q  <= '0;
            a_q    <= '0;
            b_q    <= '0;
            a_en_q <= 1'b0;
            b_en_q <= 1'b0;
            ld_q   <= 1'b0;
            br_q   <= 1'b0;
         end else if (ins_en && sel[i]) begin
            v_q    <= 1'b1;
            stg_q  <= S_EX;
            dst_q  <= ins_dst;
            a_q    <= ins_a;
            b_q    <= ins_b;
            a_en_q <= ins_a_en;
            b_en_q <= ins_b_en;
            ld_q   <= ins_ld;
            br_q   <= ins_br;
         end else if (v_q) begin
            if (stg_q == S_WB) v_q <= 1'b0;
            else               stg_q <= stg_q + STG_W'(1);
         end
      end

      assign e_v[i]    = v_q;
      assign e_dst[i]  = dst_q;
      assign e_a[i]    = a_q;
      assign e_a_en[i] = a_en_q;
      assign e_b[i]    = b_q;
      assign e_b_en[i] = b_en_q;
      assign e_ld[i]   = ld_q;
      assign e_br[i]   = br_q;
      assign e_stg[i]  = stg_q;
   end
endmodule

// File: rtl/hz_compare.sv
module hz_compare #(
   parameter int REG_W   = 5,
   parameter int DEPTH   = 4,
   parameter int STG_W   = 3,
   parameter int STG_EX  = 3,
   parameter int STG_MEM = 4,
   parameter int STG_WB  = 5,
   parameter int RD_LAST = 3,
   parameter int BR_WAIT = 2
) (
   input  logic [REG_W-1:0]                n_dst,
   input  logic [REG_W-1:0]                n_a,
   input  logic                            n_a_en,
   input  logic [REG_W-1:0]                n_b,
   input  logic                            n_b_en,
   input  logic [DEPTH-1:0]                e_v,
   input  logic [DEPTH-1:0][REG_W-1:0]     e_dst,
   input  logic [DEPTH-1:0][REG_W-1:0]     e_a,
   input  logic [DEPTH-1:0]                e_a_en,
   input  logic [DEPTH-1:0][REG_W-1:0]     e_b,
   input  logic [DEPTH-1:0]                e_b_en,
   input  logic [DEPTH-1:0]                e_ld,
   input  logic [DEPTH-1:0]                e_br,
   input  logic [DEPTH-1:0][STG_W-1:0]     e_stg,
   output logic [DEPTH-1:0]                raw_v,
   output logic [DEPTH-1:0]                waw_v,
   output logic [DEPTH-1:0]                war_v,
   output logic [DEPTH-1:0]                fwd_v,
   output logic [DEPTH-1:0]                br_v,
   output logic [DEPTH-1:0]                wb_v
);
   localparam logic [STG_W-1:0] S_EX  = STG_W'(STG_EX);
   localparam logic [STG_W-1:0] S_MEM = STG_W'(STG_MEM);
   localparam logic [STG_W-1:0] S_WB  = STG_W'(STG_WB);
   localparam logic [STG_W-1:0] S_RD  = STG_W'(RD_LAST);
   localparam logic [STG_W-1:0] S_BR  = STG_W'(STG_EX + BR_WAIT);

   logic n_wr;
   assign n_wr = |n_dst;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      logic e_wr, rd_a, rd_b;
      assign e_wr = e_v[i] && (|e_dst[i]);
      assign rd_a = e_a_en[i] && (e_a[i] == n_dst);
      assign rd_b = e_b_en[i] && (e_b[i] == n_dst);

      assign raw_v[i] = e_wr && ((n_a_en && (n_a == e_dst[i])) ||
                                 (n_b_en && (n_b == e_dst[i])));
      assign waw_v[i] = e_wr && n_wr && (n_dst == e_dst[i]);
      assign war_v[i] = e_v[i] && n_wr && (e_stg[i] <= S_RD) && (rd_a || rd_b);
      assign fwd_v[i] = e_ld[i] ? (e_stg[i] >= S_MEM) : (e_stg[i] >= S_EX);
      assign br_v[i]  = e_v[i] && e_br[i] && (e_stg[i] < S_BR);
      assign wb_v[i]  = e_v[i] && (e_stg[i] == S_WB);
   end
endmodule

// File: rtl/hz_resolve.sv
module hz_resolve
   import hz_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter int DEPTH     = 4,
   parameter bit STALL_WAW = 1'b1,
   parameter bit STALL_WAR = 1'b1
) (
   input  logic                            in_valid,
   input  logic [DEPTH-1:0]                raw_v,
   input  logic [DEPTH-1:0]                waw_v,
   input  logic [DEPTH-1:0]                war_v,
   input  logic [DEPTH-1:0]                fwd_v,
   input  logic [DEPTH-1:0]                br_v,
   input  logic [DEPTH-1:0]                wb_v,
   input  logic [DEPTH-1:0][REG_W-1:0]     e_dst,
   input  logic                            full,
   output logic                            stall,
   output logic                            issue_ok,
   output hz_kind_t                        hz_kind,
   output logic                            fwd_ok,
   output logic                            wb_en,
   output logic [REG_W-1:0]                wb_reg
);
   logic raw, waw, war, waw_blk, war_blk, raw_blk;

   assign raw = in_valid && (|raw_v);
   assign waw = in_valid && (|waw_v);
   assign war = in_valid && (|war_v);

   if (STALL_WAW) begin : g_waw_on
      assign waw_blk = waw;
   end else begin : g_waw_off
      assign waw_blk = 1'b0;
   end

   if (STALL_WAR) begin : g_war_on
      assign war_blk = war;
   end else begin : g_war_off
      assign war_blk = 1'b0;
   end

   assign fwd_ok  = raw && ((raw_v & ~fwd_v) == '0);
   assign raw_blk = raw && !fwd_ok;

   always_comb begin
      hz_kind         = '0;
      hz_kind[HK_RAW] = raw;
      hz_kind[HK_WAW] = waw;
      hz_kind[HK_WAR] = war;
   end

   assign stall    = in_valid && (raw_blk || waw_blk || war_blk || (|br_v) || full);
   assign issue_ok = in_valid && !stall;

   always_comb begin
      wb_reg = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (wb_v[i]) wb_reg = wb_reg | e_dst[i];
      end
   end
   assign wb_en = |wb_reg;
endmodule

// File: rtl/hz_issue_check.sv
module hz_issue_check
   import hz_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter int DEPTH     = 4,
   parameter int STG_W     = 3,
   parameter int STG_EX    = 3,
   parameter int STG_MEM   = 4,
   parameter int STG_WB    = 5,
   parameter int RD_LAST   = 3,
   parameter int BR_WAIT   = 2,
   parameter bit STALL_WAW = 1'b1,
   parameter bit STALL_WAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [REG_W-1:0] in_dst,
   input  logic [REG_W-1:0] in_src_a,
   input  logic             in_src_a_en,
   input  logic [REG_W-1:0] in_src_b,
   input  logic             in_src_b_en,
   input  logic             in_load,
   input  logic             in_branch,
   output logic             stall,
   output logic             issue_ok,
   output logic [HK_W-1:0]  hz_kind,
   output logic             fwd_ok,
   output logic             wb_en,
   output logic [REG_W-1:0] wb_reg
);
   localparam int LIVE_MAX = STG_WB - STG_EX + 1;

   if (DEPTH < LIVE_MAX) begin : g_chk_depth
      $error("hz_issue_check: DEPTH smaller than stages in flight");
   end
   if (STG_WB >= (1 << STG_W)) begin : g_chk_stg
      $error("hz_issue_check: STG_W too narrow for STG_WB");
   end
   if (!(STG_EX <= STG_MEM && STG_MEM <= STG_WB)) begin : g_chk_order
      $error("hz_issue_check: stage indices out of order");
   end
   if (STG_EX + BR_WAIT > STG_WB + 1) begin : g_chk_br
      $error("hz_issue_check: BR_WAIT exceeds pool lifetime");
   end

   logic [DEPTH-1:0]                e_v, e_a_en, e_b_en, e_ld, e_br;
   logic [DEPTH-1:0][REG_W-1:0]     e_dst, e_a, e_b;
   logic [DEPTH-1:0][STG_W-1:0]     e_stg;
   logic                            full;
   logic [DEPTH-1:0]                raw_v, waw_v, war_v, fwd_v, br_v, wb_v;
   hz_kind_t                        kind;

   hz_window #(
      .REG_W(REG_W), .DEPTH(DEPTH), .STG_W(STG_W),
      .STG_EX(STG_EX), .STG_WB(STG_WB)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .ins_en(issue_ok),
      .ins_dst(in_dst), .ins_a(in_src_a), .ins_a_en(in_src_a_en),
      .ins_b(in_src_b), .ins_b_en(in_src_b_en),
      .ins_ld(in_load), .ins_br(in_branch),
      .e_v(e_v), .e_dst(e_dst), .e_a(e_a), .e_a_en(e_a_en),
      .e_b(e_b), .e_b_en(e_b_en), .e_ld(e_ld), .e_br(e_br),
      .e_stg(e_stg), .full(full)
   );

   hz_compare #(
      .REG_W(REG_W), .DEPTH(DEPTH), .STG_W(STG_W), .STG_EX(STG_EX),
      .STG_MEM(STG_MEM), .STG_WB(STG_WB), .RD_LAST(RD_LAST), .BR_WAIT(BR_WAIT)
   ) u_cmp (
      .n_dst(in_dst), .n_a(in_src_a), .n_a_en(in_src_a_en),
      .n_b(in_src_b), .n_b_en(in_src_b_en),
      .e_v(e_v), .e_dst(e_dst), .e_a(e_a), .e_a_en(e_a_en),
      .e_b(e_b), .e_b_en(e_b_en), .e_ld(e_ld), .e_br(e_br), .e_stg(e_stg),
      .raw_v(raw_v), .waw_v(waw_v), .war_v(war_v),
      .fwd_v(fwd_v), .br_v(br_v), .wb_v(wb_v)
   );

   hz_resolve #(
      .REG_W(REG_W), .DEPTH(DEPTH),
      .STALL_WAW(STALL_WAW), .STALL_WAR(STALL_WAR)
   ) u_res (
      .in_valid(in_valid), .raw_v(raw_v), .waw_v(waw_v), .war_v(war_v),
      .fwd_v(fwd_v), .br_v(br_v), .wb_v(wb_v), .e_dst(e_dst), .full(full),
      .stall(stall), .issue_ok(issue_ok), .hz_kind(kind), .fwd_ok(fwd_ok),
      .wb_en(wb_en), .wb_reg(wb_reg)
   );

   assign hz_kind = kind;
endmodule

// File: rtl/hz_issue_check_sva.sv
module hz_issue_check_sva #(
   parameter int REG_W     = 5,
   parameter int DEPTH     = 4,
   parameter bit STALL_WAW = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [REG_W-1:0] in_dst,
   input logic             stall,
   input logic             issue_ok,
   input logic [2:0]       hz_kind,
   input logic             fwd_ok,
   input logic             wb_en,
   input logic [REG_W-1:0] wb_reg,
   input logic [DEPTH-1:0] at_wb
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!stall && !issue_ok && hz_kind == 3'b000 && !fwd_ok));

   p_fwd_needs_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_ok |-> hz_kind[0]);

   p_unbypassed_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && hz_kind[0] && !fwd_ok) |-> stall);

   if (STALL_WAW) begin : g_waw
      p_waw_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && hz_kind[1]) |-> stall);
   end

   p_no_reg0_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_reg != '0));

   p_wb_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> ($past(issue_ok, 3) && wb_reg == $past(in_dst, 3)));

   p_single_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(at_wb) <= 1);

   p_issue_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      issue_ok |-> (in_valid && !stall));
endmodule

bind hz_issue_check hz_issue_check_sva #(
   .REG_W(REG_W), .DEPTH(DEPTH), .STALL_WAW(STALL_WAW)
) u_sva (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
   .stall(stall), .issue_ok(issue_ok), .hz_kind(hz_kind), .fwd_ok(fwd_ok),
   .wb_en(wb_en), .wb_reg(wb_reg), .at_wb(wb_v)
);

// File: tb/tb_hz_issue_check.sv
module tb_hz_issue_check;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid, in_src_a_en, in_src_b_en, in_load, in_branch;
   logic [4:0] in_dst, in_src_a, in_src_b;
   logic       stall, issue_ok, fwd_ok, wb_en;
   logic [2:0] hz_kind;
   logic [4:0] wb_reg;

   int n_chk  = 0;
   int n_fail = 0;

   typedef struct {
      bit         x_stall;
      bit         x_issue;
      logic [2:0] x_kind;
      bit         x_fwd;
      bit         x_wb;
      logic [4:0] x_reg;
      string      tag;
   } exp_t;

   exp_t q[$];

   always #5 clk = ~clk;

   hz_issue_check dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
      .in_src_a(in_src_a), .in_src_a_en(in_src_a_en),
      .in_src_b(in_src_b), .in_src_b_en(in_src_b_en),
      .in_load(in_load), .in_branch(in_branch),
      .stall(stall), .issue_ok(issue_ok), .hz_kind(hz_kind), .fwd_ok(fwd_ok),
      .wb_en(wb_en), .wb_reg(wb_reg)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int xp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, xp);
      end
   endtask

   // driver: presents one instruction for one cycle and queues the expectation
   task automatic step(input bit v, input logic [4:0] d, input logic [4:0] a,
                       input bit ae, input logic [4:0] b, input bit be,
                       input bit ld, input bit br,
                       input bit xs, input logic [2:0] xk, input bit xf,
                       input bit xw, input logic [4:0] xr, input string tag);
      exp_t e;
      @(negedge clk);
      in_valid = v; in_dst = d; in_src_a = a; in_src_a_en = ae;
      in_src_b = b; in_src_b_en = be; in_load = ld; in_branch = br;
      e.x_stall = xs; e.x_issue = v && !xs; e.x_kind = xk; e.x_fwd = xf;
      e.x_wb = xw; e.x_reg = xr; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(input bit xw, input logic [4:0] xr, input string tag);
      step(1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0,
           1'b0, 3'b000, 1'b0, xw, xr, tag);
   endtask

   // monitor: samples mid-cycle, well away from the rising edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(stall == e.x_stall, e.tag, "stall", int'(stall), int'(e.x_stall));
            chk(hz_kind == e.x_kind, e.tag, "hz_kind", int'(hz_kind), int'(e.x_kind));
            chk(fwd_ok == e.x_fwd, e.tag, "fwd_ok", int'(fwd_ok), int'(e.x_fwd));
            chk(issue_ok == e.x_issue, "R11", "issue_ok", int'(issue_ok), int'(e.x_issue));
            chk(wb_en == e.x_wb, "R10", "wb_en", int'(wb_en), int'(e.x_wb));
            if (e.x_wb)
               chk(wb_reg == e.x_reg, "R10", "wb_reg", int'(wb_reg), int'(e.x_reg));
         end
      end
   end

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   localparam logic [2:0] K0 = 3'b000, KRAW = 3'b001, KWAW = 3'b010,
                          KWAR = 3'b100, KRW = 3'b011;

   initial begin
      rst_n = 1'b0;
      in_valid = 0; in_dst = 0; in_src_a = 0; in_src_a_en = 0;
      in_src_b = 0; in_src_b_en = 0; in_load = 0; in_branch = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, idle inputs
      idle(1'b0, 5'd0, "R1");
      // ALU chain with bypass
      step(1, 5'd1, 5'd2, 1, 5'd3, 1, 0, 0,  0, K0,   0, 0, 5'd0, "R9");
      step(1, 5'd5, 5'd1, 1, 5'd4, 1, 0, 0,  0, KRAW, 1, 0, 5'd0, "R2/R3");
      step(1, 5'd6, 5'd7, 1, 5'd1, 0, 0, 0,  0, K0,   0, 0, 5'd0, "R2 disabled src");
      step(1, 5'd0, 5'd0, 1, 5'd0, 1, 0, 0,  0, K0,   0, 1, 5'd1, "R7");
      step(1, 5'd0, 5'd0, 1, 5'd5, 1, 0, 0,  0, KRAW, 1, 1, 5'd5, "R7/R3");
      idle(1'b1, 5'd6, "R10");
      idle(1'b0, 5'd0, "R7 no wb of r0");
      idle(1'b0, 5'd0, "R10");
      idle(1'b0, 5'd0, "R9 drained");
      // load-use
      step(1, 5'd9,  5'd10, 1, 5'd0, 0, 1, 0,  0, K0,   0, 0, 5'd0, "R4");
      step(1, 5'd11, 5'd9,  1, 5'd0, 0, 0, 0,  1, KRAW, 0, 0, 5'd0, "R4");
      step(1, 5'd11, 5'd9,  1, 5'd0, 0, 0, 0,  0, KRAW, 1, 0, 5'd0, "R4/R3");
      idle(1'b1, 5'd9,  "R10 load wb");
      idle(1'b0, 5'd0,  "R9");
      idle(1'b1, 5'd11, "R10");
      idle(1'b0, 5'd0,  "R9");
      // write-after-write held across the producer's lifetime
      step(1, 5'd12, 5'd13, 1, 5'd14, 1, 0, 0,  0, K0,   0, 0, 5'd0,  "R5");
      step(1, 5'd12, 5'd15, 1, 5'd0,  0, 0, 0,  1, KWAW, 0, 0, 5'd0,  "R5");
      step(1, 5'd12, 5'd15, 1, 5'd0,  0, 0, 0,  1, KWAW, 0, 0, 5'd0,  "R5");
      step(1, 5'd12, 5'd15, 1, 5'd0,  0, 0, 0,  1, KWAW, 0, 1, 5'd12, "R5 stage5");
      step(1, 5'd12, 5'd15, 1, 5'd0,  0, 0, 0,  0, K0,   0, 0, 5'd0,  "R9 released");
      // write-after-read against a reader still in stage 3
      step(1, 5'd15, 5'd16, 1, 5'd0,  0, 0, 0,  1, KWAR, 0, 0, 5'd0,  "R6");
      step(1, 5'd15, 5'd16, 1, 5'd0,  0, 0, 0,  0, K0,   0, 0, 5'd0,  "R6 read done");
      idle(1'b1, 5'd12, "R9 held instr inserted once");
      idle(1'b0, 5'd0,  "R10");
      idle(1'b1, 5'd15, "R10");
      idle(1'b0, 5'd0,  "R9");
      // branch waits
      step(1, 5'd0,  5'd1,  1, 5'd2, 1, 0, 1,  0, K0,  0, 0, 5'd0, "R8");
      step(1, 5'd20, 5'd21, 1, 5'd0, 0, 0, 0,  1, K0,  0, 0, 5'd0, "R8");
      step(1, 5'd20, 5'd21, 1, 5'd0, 0, 0, 0,  1, K0,  0, 0, 5'd0, "R8");
      step(1, 5'd20, 5'd21, 1, 5'd0, 0, 0, 0,  0, K0,  0, 0, 5'd0, "R8");
      // combined RAW and WAW on the same register
      step(1, 5'd20, 5'd20, 1, 5'd0, 0, 0, 0,  1, KRW, 1, 0, 5'd0, "R5/R3");
      idle(1'b0, 5'd0,  "R9");
      idle(1'b1, 5'd20, "R10");
      idle(1'b0, 5'd0,  "R9");

      while (q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule